// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that gives a bus master access to a small bank of 16-bit registers selected by an 8-bit register pointer. SCL and SDA arrive already synchronised to the system clock. The block pulls SDA low through an open-drain enable for its acknowledges and read data, and otherwise leaves the line released.

A master sets the pointer with a write-form transaction. It then either streams 16-bit words, high byte first, or issues a repeated start with the read-form device byte and clocks words back out. A word reaches the bank only once both of its bytes have arrived. The pointer then moves on by one register per word. A separate staging address lets the master write a register one byte at a time: the high byte goes to the target register, and the low byte follows to the staging address.

Top module: `twi_regport`

## Requirements
- R1: The 7-bit device address is 0x5D (parameter). The block acknowledges both the write-form byte 0xBA and the read-form byte 0xBB. An acknowledge means SDA is held low during the ninth SCL high phase.
- R2: A device byte whose upper 7 bits differ from the device address is not acknowledged. SDA stays released, and following bytes have no effect, until the next start condition.
- R3: In a write, the block acknowledges every received byte after a matching device byte: the register pointer byte and each data byte.
- R4: The first byte after 0xBA loads the register pointer. Each following pair of bytes is one word: high byte first, and each byte arrives MSB first.
- R5: A register changes only when both bytes of a word have arrived. A lone high byte followed by a stop leaves the register at its old value.
- R6: After each written word, the pointer advances by one, so the next pair of bytes goes to the following register.
- R7: A stop or a repeated start ends a write burst. A high byte left pending by a repeated start is not written by the next normal word.
- R8: A read returns the word at the pointer, high byte first, MSB first. While the master acknowledges, the block keeps sending. The pointer advances by one after the second byte of each word.
- R9: A master NACK after a read byte ends the read. SDA stays released for any further SCL pulses until the next start condition.
- R10: Byte-wide write: the master sends a high byte to target register T, issues a repeated start, and then sends the pointer byte 0xF1 followed by the low byte. The block writes {high, low} to T.
- R11: A stop that arrives after a staged high byte and before the 0xF1 low byte discards the staged byte. T keeps its old value.
- R12: The block changes its SDA drive only while SCL is low. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.
- R13: After reset, every register reads 0x0000 and SDA is released. Register indices at or above the bank size (32) read as 0x0000, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock line level |
| sda_i | input | 1 | Synchronised serial data line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
On the SCL rising edge of a word's low byte, the bank write and the pointer increment happen in the same cycle. In a read, the master-acknowledge edge advances the pointer, and the next byte is fetched from the new pointer at the following SCL fall. Both coincidences are provoked by multi-word write bursts that cross a register boundary, including a burst that runs past the end of the bank. Each is followed by a multi-word read from the burst's base. A result is judged correct only if every register returns its own word, with no word shifted or duplicated into a neighbour.

// File: rtl/twi_regport_pkg.sv
package twi_regport_pkg;

   localparam int BYTE_W     = 8;
   localparam int WORD_W     = 2 * BYTE_W;
   localparam int REG_ADDR_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK_WAIT,
      PH_ACK,
      PH_TX,
      PH_MACK,
      PH_MACK_WAIT,
      PH_SKIP
   } twi_phase_e;

   typedef enum logic [1:0] {
      BK_DEV,
      BK_REG,
      BK_HI,
      BK_LO
   } byte_kind_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
   } line_ev_t;

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events
   import twi_regport_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output line_ev_t ev_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= IDLE_LEVEL;
         sda_q <= IDLE_LEVEL;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign ev_o.rise  = scl_i & ~scl_q;
   assign ev_o.fall  = ~scl_i & scl_q;
   assign ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
   assign ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_reg_array.sv
module twi_reg_array
   import twi_regport_pkg::*;
#(
   parameter int                NUM_REGS  = 32,
   parameter int                ADDR_W    = REG_ADDR_W,
   parameter int                DATA_W    = WORD_W,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("twi_reg_array: NUM_REGS out of range");
   end

   logic [DATA_W-1:0] regs [NUM_REGS];
   logic              wr_in_range;
   logic              rd_in_range;

   if (NUM_REGS == (1 << ADDR_W)) begin : g_full_map
      assign wr_in_range = 1'b1;
      assign rd_in_range = 1'b1;
   end else begin : g_part_map
      localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);
      assign wr_in_range = ({1'b0, wr_addr_i} < LIMIT);
      assign rd_in_range = ({1'b0, rd_addr_i} < LIMIT);
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= RESET_VAL;
         end else if (wr_en_i && wr_in_range && (wr_addr_i[IDX_W-1:0] == IDX_W'(i))) begin
            regs[i] <= wr_data_i;
         end
      end
   end

   assign rd_data_o = rd_in_range ? regs[rd_addr_i[IDX_W-1:0]] : '0;

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
   import twi_regport_pkg::*;
#(
   parameter int                ADDR_W     = REG_ADDR_W,
   parameter int                DATA_W     = WORD_W,
   parameter logic [6:0]        DEV_ADDR   = 7'h5D,
   parameter logic [ADDR_W-1:0] STAGE_ADDR = 8'hF1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i
);

   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   if (DATA_W != 2 * BYTE_W) begin : g_bad_word
      $error("twi_proto_fsm: word must be two bytes");
   end
   if (ADDR_W != BYTE_W) begin : g_bad_addr
      $error("twi_proto_fsm: register pointer must be one byte");
   end

   twi_phase_e        phase_q;
   byte_kind_e        kind_q;
   logic [BIT_W-1:0]  bitcnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic              sda_oe_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [BYTE_W-1:0] hi_byte_q;
   logic [ADDR_W-1:0] hi_tgt_q;
   logic              hi_valid_q;
   logic              rd_lo_q;
   logic              go_tx_q;
   logic              tx_done_q;
   logic              wr_en_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;

   logic [BYTE_W-1:0] rx_byte;
   logic [BYTE_W-1:0] tx_byte;

   assign rx_byte = {shreg_q[BYTE_W-2:0], sda_i};
   assign tx_byte = rd_lo_q ? rd_data_i[BYTE_W-1:0] : rd_data_i[DATA_W-1:BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         kind_q     <= BK_DEV;
         bitcnt_q   <= '0;
         shreg_q    <= '0;
         sda_oe_q   <= 1'b0;
         ptr_q      <= '0;
         hi_byte_q  <= '0;
         hi_tgt_q   <= '0;
         hi_valid_q <= 1'b0;
         rd_lo_q    <= 1'b0;
         go_tx_q    <= 1'b0;
         tx_done_q  <= 1'b0;
         wr_en_q    <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (ev_i.stop) begin
            phase_q    <= PH_IDLE;
            sda_oe_q   <= 1'b0;
            hi_valid_q <= 1'b0;
         end else if (ev_i.start) begin
            phase_q  <= PH_RX;
            kind_q   <= BK_DEV;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_RX: begin
                  if (ev_i.rise) begin
                     shreg_q  <= rx_byte;
                     bitcnt_q <= bitcnt_q + 1'b1;
                     if (bitcnt_q == LAST_BIT) begin
                        phase_q <= PH_ACK_WAIT;
                        go_tx_q <= 1'b0;
                        unique case (kind_q)
                           BK_DEV: begin
                              if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                                 go_tx_q <= rx_byte[0];
                                 rd_lo_q <= 1'b0;
                                 kind_q  <= BK_REG;
                              end else begin
                                 phase_q <= PH_SKIP;
                              end
                           end
                           BK_REG: begin
                              ptr_q  <= rx_byte;
                              kind_q <= BK_HI;
                           end
                           default: begin
                              if (ptr_q == STAGE_ADDR) begin
                                 if (hi_valid_q) begin
                                    wr_en_q    <= 1'b1;
                                    wr_addr_q  <= hi_tgt_q;
                                    wr_data_q  <= {hi_byte_q, rx_byte};
                                    hi_valid_q <= 1'b0;
                                 end
                              end else if (kind_q == BK_HI) begin
                                 hi_byte_q  <= rx_byte;
                                 hi_tgt_q   <= ptr_q;
                                 hi_valid_q <= 1'b1;
                                 kind_q     <= BK_LO;
                              end else begin
                                 wr_en_q    <= 1'b1;
                                 wr_addr_q  <= ptr_q;
                                 wr_data_q  <= {hi_byte_q, rx_byte};
                                 ptr_q      <= ptr_q + ADDR_W'(1);
                                 hi_valid_q <= 1'b0;
                                 kind_q     <= BK_HI;
                              end
                           end
                        endcase
                     end
                  end
               end
               PH_ACK_WAIT: begin
                  if (ev_i.fall) begin
                     sda_oe_q <= 1'b1;
                     phase_q  <= PH_ACK;
                  end
               end
               PH_ACK: begin
                  if (ev_i.fall) begin
                     bitcnt_q <= '0;
                     if (go_tx_q) begin
                        sda_oe_q  <= ~tx_byte[BYTE_W-1];
                        shreg_q   <= {tx_byte[BYTE_W-2:0], 1'b0};
                        tx_done_q <= 1'b0;
                        phase_q   <= PH_TX;
                     end else begin
                        sda_oe_q <= 1'b0;
                        phase_q  <= PH_RX;
                     end
                  end
               end
               PH_TX: begin
                  if (ev_i.rise) begin
                     bitcnt_q <= bitcnt_q + 1'b1;
                     if (bitcnt_q == LAST_BIT) begin
                        tx_done_q <= 1'b1;
                     end
                  end else if (ev_i.fall) begin
                     if (tx_done_q) begin
                        sda_oe_q  <= 1'b0;
                        tx_done_q <= 1'b0;
                        phase_q   <= PH_MACK;
                     end else begin
                        sda_oe_q <= ~shreg_q[BYTE_W-1];
                        shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               PH_MACK: begin
                  if (ev_i.rise) begin
                     if (sda_i) begin
                        phase_q <= PH_SKIP;
                     end else begin
                        phase_q <= PH_MACK_WAIT;
                        rd_lo_q <= ~rd_lo_q;
                        if (rd_lo_q) begin
                           ptr_q <= ptr_q + ADDR_W'(1);
                        end
                     end
                  end
               end
               PH_MACK_WAIT: begin
                  if (ev_i.fall) begin
                     bitcnt_q  <= '0;
                     sda_oe_q  <= ~tx_byte[BYTE_W-1];
                     shreg_q   <= {tx_byte[BYTE_W-2:0], 1'b0};
                     tx_done_q <= 1'b0;
                     phase_q   <= PH_TX;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign sda_oe_o  = sda_oe_q;
   assign wr_en_o   = wr_en_q;
   assign wr_addr_o = wr_addr_q;
   assign wr_data_o = wr_data_q;
   assign rd_addr_o = ptr_q;

   // R2
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SKIP) |-> !sda_oe_q);

   // R3
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ACK) |-> sda_oe_q);

   // R5
   single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |=> !wr_en_q);

   // R6
   post_write_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> ((ptr_q == STAGE_ADDR) || (ptr_q == wr_addr_q + ADDR_W'(1))));

   // R11
   staged_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i.stop |=> !hi_valid_q);

endmodule

// File: rtl/twi_regport.sv
module twi_regport
   import twi_regport_pkg::*;
#(
   parameter logic [6:0]            DEV_ADDR   = 7'h5D,
   parameter int                    NUM_REGS   = 32,
   parameter logic [REG_ADDR_W-1:0] STAGE_ADDR = 8'hF1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);

   if (int'(STAGE_ADDR) < NUM_REGS) begin : g_bad_stage
      $error("twi_regport: staging address overlaps the register bank");
   end

   line_ev_t              ev;
   logic                  wr_en;
   logic [REG_ADDR_W-1:0] wr_addr;
   logic [WORD_W-1:0]     wr_data;
   logic [REG_ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0]     rd_data;

   twi_line_events #(
      .IDLE_LEVEL (1'b1)
   ) i_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev_o  (ev)
   );

   twi_proto_fsm #(
      .ADDR_W     (REG_ADDR_W),
      .DATA_W     (WORD_W),
      .DEV_ADDR   (DEV_ADDR),
      .STAGE_ADDR (STAGE_ADDR)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_i      (ev),
      .sda_i     (sda_i),
      .sda_oe_o  (sda_oe_o),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data)
   );

   twi_reg_array #(
      .NUM_REGS  (NUM_REGS),
      .ADDR_W    (REG_ADDR_W),
      .DATA_W    (WORD_W),
      .RESET_VAL ('0)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   // R12
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !$past(scl_i));

endmodule

// File: tb/test_twi_regport.sv
module test_twi_regport;

   localparam int Q = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;

   int n_chk = 0;
   int n_fail = 0;
   int r12_viol = 0;

   int    exp_q[$];
   int    obs_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   twi_regport i_twi_regport (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares against observed results
   initial begin
      forever begin
         @(negedge clk);
         if (obs_q.size() > 0 && exp_q.size() > 0) begin
            int e;
            int o;
            string t;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            t = tag_q.pop_front();
            check(o == e, t, o, e);
         end
      end
   end

   // R12: SDA drive may only change while SCL is low
   logic scl_d = 1'b1;
   logic oe_d = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_d && (sda_oe !== oe_d)) r12_viol++;
      scl_d <= scl_m;
      oe_d  <= sda_oe;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(2 * Q);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b;    wait_clk(Q);
      scl_m = 1'b1; wait_clk(2 * Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      b = sda_line; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   // driver: sends a byte and queues the expected acknowledge (1 = ACK)
   task automatic send(input logic [7:0] b, input int exp_ack, input string tag);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      exp_q.push_back(exp_ack);
      tag_q.push_back(tag);
      obs_q.push_back(a ? 0 : 1);
   endtask

   task automatic recv(input logic [7:0] exp, input bit give_ack, input bit ack_slot,
                       input string tag);
      logic [7:0] got;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         got[i] = b;
      end
      exp_q.push_back(int'(exp));
      tag_q.push_back(tag);
      obs_q.push_back(int'(got));
      if (ack_slot) bit_out(give_ack ? 1'b0 : 1'b1);
   endtask

   task automatic wr_word(input logic [7:0] ra, input logic [15:0] d, input string tag);
      bus_start();
      send(8'hBA, 1, {tag, " dev ack"});
      send(ra, 1, {tag, " ptr ack"});
      send(d[15:8], 1, {tag, " hi ack"});
      send(d[7:0], 1, {tag, " lo ack"});
      bus_stop();
   endtask

   task automatic rd_word(input logic [7:0] ra, input logic [15:0] exp, input string tag);
      bus_start();
      send(8'hBA, 1, {tag, " dev ack"});
      send(ra, 1, {tag, " ptr ack"});
      bus_start();
      send(8'hBB, 1, {tag, " R1 read dev ack"});
      recv(exp[15:8], 1'b1, 1'b1, {tag, " hi"});
      recv(exp[7:0], 1'b0, 1'b1, {tag, " lo"});
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait_clk(5);
      check(sda_oe == 1'b0, "R13 SDA released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      wait_clk(5);
      check(sda_oe == 1'b0, "R13 SDA released after reset", int'(sda_oe), 0);

      rd_word(8'h03, 16'h0000, "R13 reset value");

      // R1 R3 R4 R6: three-word burst from 0x09
      bus_start();
      send(8'hBA, 1, "R1 write dev ack");
      send(8'h09, 1, "R3 ptr ack");
      send(8'h02, 1, "R3 data ack");
      send(8'h84, 1, "R3 data ack");
      send(8'h12, 1, "R6 data ack");
      send(8'h34, 1, "R6 data ack");
      send(8'hAB, 1, "R6 data ack");
      send(8'hCD, 1, "R6 data ack");
      bus_stop();

      // R8: burst read back across three registers
      bus_start();
      send(8'hBA, 1, "R8 dev ack");
      send(8'h09, 1, "R8 ptr ack");
      bus_start();
      send(8'hBB, 1, "R1 read dev ack");
      recv(8'h02, 1'b1, 1'b1, "R4 reg09 hi");
      recv(8'h84, 1'b1, 1'b1, "R4 reg09 lo");
      recv(8'h12, 1'b1, 1'b1, "R6 R8 reg0A hi");
      recv(8'h34, 1'b1, 1'b1, "R6 R8 reg0A lo");
      recv(8'hAB, 1'b1, 1'b1, "R6 R8 reg0B hi");
      recv(8'hCD, 1'b0, 1'b1, "R6 R8 reg0B lo");
      bus_stop();

      // R9: NACK ends the read, further clocks see a released line
      bus_start();
      send(8'hBA, 1, "R9 dev ack");
      send(8'h0A, 1, "R9 ptr ack");
      bus_start();
      send(8'hBB, 1, "R9 read dev ack");
      recv(8'h12, 1'b1, 1'b1, "R9 hi");
      recv(8'h34, 1'b0, 1'b1, "R9 lo then NACK");
      recv(8'hFF, 1'b0, 1'b0, "R9 released after NACK");
      bus_stop();

      // R5: lone high byte then stop
      bus_start();
      send(8'hBA, 1, "R5 dev ack");
      send(8'h0C, 1, "R5 ptr ack");
      send(8'h55, 1, "R5 hi ack");
      bus_stop();
      rd_word(8'h0C, 16'h0000, "R5 lone hi unchanged");

      // R7: repeated start ends the burst; pending hi byte not used
      bus_start();
      send(8'hBA, 1, "R7 dev ack");
      send(8'h0D, 1, "R7 ptr ack");
      send(8'h77, 1, "R7 hi ack");
      bus_start();
      send(8'hBA, 1, "R7 dev ack 2");
      send(8'h0E, 1, "R7 ptr ack 2");
      send(8'h11, 1, "R7 hi ack 2");
      send(8'h22, 1, "R7 lo ack 2");
      bus_stop();
      rd_word(8'h0D, 16'h0000, "R7 reg0D untouched");
      rd_word(8'h0E, 16'h1122, "R7 reg0E");

      // R10: byte-wide write through staging address
      bus_start();
      send(8'hBA, 1, "R10 dev ack");
      send(8'h10, 1, "R10 ptr ack");
      send(8'hA5, 1, "R10 hi ack");
      bus_start();
      send(8'hBA, 1, "R10 dev ack 2");
      send(8'hF1, 1, "R10 stage ptr ack");
      send(8'h5A, 1, "R10 lo ack");
      bus_stop();
      rd_word(8'h10, 16'hA55A, "R10 reg10");

      // R11: stop before the staging write discards the high byte
      bus_start();
      send(8'hBA, 1, "R11 dev ack");
      send(8'h11, 1, "R11 ptr ack");
      send(8'hC3, 1, "R11 hi ack");
      bus_stop();
      bus_start();
      send(8'hBA, 1, "R11 dev ack 2");
      send(8'hF1, 1, "R11 stage ptr ack");
      send(8'h3C, 1, "R11 lo ack");
      bus_stop();
      rd_word(8'h11, 16'h0000, "R11 reg11 unchanged");

      // R2: foreign device byte, following bytes ignored
      bus_start();
      send(8'hB4, 0, "R2 foreign dev no ack");
      send(8'h09, 0, "R2 no ack after mismatch");
      send(8'hFF, 0, "R2 no ack after mismatch");
      send(8'hFF, 0, "R2 no ack after mismatch");
      bus_stop();
      rd_word(8'h09, 16'h0284, "R2 reg09 unchanged");

      // R13 R6: burst past the end of the bank
      bus_start();
      send(8'hBA, 1, "R13 dev ack");
      send(8'h1F, 1, "R13 ptr ack");
      send(8'hBE, 1, "R13 data ack");
      send(8'hEF, 1, "R13 data ack");
      send(8'h55, 1, "R13 data ack");
      send(8'h55, 1, "R13 data ack");
      bus_stop();
      bus_start();
      send(8'hBA, 1, "R13 dev ack");
      send(8'h1F, 1, "R13 ptr ack");
      bus_start();
      send(8'hBB, 1, "R13 read dev ack");
      recv(8'hBE, 1'b1, 1'b1, "R13 reg1F hi");
      recv(8'hEF, 1'b1, 1'b1, "R13 reg1F lo");
      recv(8'h00, 1'b1, 1'b1, "R13 reg20 hi");
      recv(8'h00, 1'b0, 1'b1, "R13 reg20 lo");
      bus_stop();
      wr_word(8'h40, 16'h1234, "R13 out-of-range write");
      rd_word(8'h40, 16'h0000, "R13 out-of-range read");
      rd_word(8'hF1, 16'h0000, "R13 staging address read");

      wait_clk(20);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      check(r12_viol == 0, "R12 SDA changed while SCL high", r12_viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule